// File: doc/BRIEF.md
# Mixed-Width Register Bus Adapter

The adapter connects a big-endian processor port to a bank of peripheral registers whose native widths differ: some are 8 bits, some 16 and some 32. The processor may issue byte, halfword or word requests at any register. A built-in width table gives the native width of every 4-byte group of the register space. The adapter turns each request into one or more accesses at that native width.

A request wider than the register becomes a run of native accesses in ascending address order. The lowest address carries the most significant part of the data. A read narrower than the register becomes one aligned native read, from which the addressed lane is picked. A write narrower than the register becomes a read of the aligned native register, a merge of the new lane into it, and a write back.

Requests that fall outside the mapped space complete with an error flag and never reach the registers. This covers offsets beyond the limit, groups the table leaves unimplemented, misaligned requests and the reserved size code.

Top module: `mwb_adapter`

## Requirements
- R1: Only the low 10 bits of `req_addr` form the register offset; requests whose addresses differ only above bit 9 reach the same register.
- R2: An offset above 0x200 completes with `rsp_err`=1 and `rsp_rdata`=0, with no register access, and `rsp_ready` rises one cycle after acceptance.
- R3: Each 4-byte group g (offset bits 9:2) has a native width code on `reg_width` of 1=8, 2=16, 3=32 or 0=unimplemented. For g >= 0x80 the code is 0. Otherwise g[4:3]=0 gives 8 bits, 1 gives 16 and 2 gives 32; 3 gives 8 bits when g[0]=0 and unimplemented when g[0]=1. A request to an unimplemented group errors in the same way as R2.
- R4: `req_size` encodes 0=byte, 1=halfword, 2=word. Code 3, a halfword at an odd offset, or a word at an offset not a multiple of 4 errors in the same way as R2.
- R5: A request equal to the native width makes exactly one register access at the request offset, with the same data.
- R6: A byte or halfword read of a wider register makes one read at the offset aligned down to the native width. It returns that register's lane, right-justified in `rsp_rdata`; the lowest offset selects the most significant lane.
- R7: A halfword read of an 8-bit register makes two byte reads, offset first and offset+1 second; the first supplies `rsp_rdata[15:8]`.
- R8: A word read of a narrower register makes 2 (16-bit) or 4 (8-bit) native reads in ascending address order; the lowest address supplies the most significant bits.
- R9: A write narrower than the register reads the aligned native register and then writes it back at the same address with only the addressed lane replaced (lowest offset = most significant lane). All other bytes keep their values.
- R10: A write wider than the register makes native writes in ascending address order, each carrying the next lower part of `req_wdata` starting from the most significant.
- R11: `rsp_ready` is a one-cycle pulse exactly N+1 cycles after acceptance, where N is the number of register accesses. `busy` is high from acceptance through that pulse, and a `req_valid` while busy is not accepted and has no effect.
- R12: `reg_valid` pulses once per register access; the register bank returns read data on `reg_rdata` in the same cycle, right-justified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (R4) |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | 32 | Write data, right-justified |
| busy | output | 1 | Request in progress |
| rsp_ready | output | 1 | Completion pulse |
| rsp_err | output | 1 | Completion carries an error |
| rsp_rdata | output | 32 | Read data, right-justified |
| reg_valid | output | 1 | Register access this cycle |
| reg_write | output | 1 | Register access is a write |
| reg_width | output | 2 | Native width code of the access |
| reg_addr | output | OFFS_W | Register offset, aligned to native width |
| reg_wdata | output | 32 | Register write data, right-justified |
| reg_rdata | input | 32 | Register read data, same cycle |

## Verification
The bench builds the adapter with its defaults: a 16-bit request address, a 10-bit offset and a 0x200 limit. These keep the whole offset space at 1024 bytes. Every offset is swept with every size code, as a write followed by a read, and the upper address bits vary to expose aliasing. This brings every width pairing and every lane position into reach. Every misalignment and both error causes are covered too, as are the boundary groups around 0x1FC and 0x200.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    AS_BYTE = 2'd0,
    AS_HALF = 2'd1,
    AS_WORD = 2'd2,
    AS_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    NW_NONE = 2'd0,
    NW_8    = 2'd1,
    NW_16   = 2'd2,
    NW_32   = 2'd3
  } nat_width_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  // Native width of a 4-byte group in the default register layout.
  function automatic logic [1:0] default_group_width(int g, int first_unmapped);
    int sel;
    if (g >= first_unmapped) return NW_NONE;
    sel = (g >> 3) & 3;
    case (sel)
      0:       return NW_8;
      1:       return NW_16;
      2:       return NW_32;
      default: return ((g & 1) != 0) ? NW_NONE : NW_8;
    endcase
  endfunction

  // All-ones mask of 2**lg bytes.
  function automatic logic [BUS_W-1:0] lane_mask(logic [1:0] lg);
    case (lg)
      2'd0:    return 32'h0000_00ff;
      2'd1:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  // Bit position of an access lane inside a wider native register, big-endian.
  function automatic logic [4:0] lane_shift(logic [1:0] alg, logic [1:0] nlg, logic [1:0] low);
    int nb;
    int ab;
    int pos;
    int s;
    nb  = 1 << nlg;
    ab  = 1 << alg;
    pos = int'(low) & (nb - 1);
    s   = (nb - ab - pos) * 8;
    return s[4:0];
  endfunction

  function automatic logic [BUS_W-1:0] pick_lane(logic [BUS_W-1:0] w, logic [1:0] alg,
                                                 logic [1:0] nlg, logic [1:0] low);
    return (w >> lane_shift(alg, nlg, low)) & lane_mask(alg);
  endfunction

  function automatic logic [BUS_W-1:0] put_lane(logic [BUS_W-1:0] old, logic [BUS_W-1:0] val,
                                                logic [1:0] alg, logic [1:0] nlg, logic [1:0] low);
    logic [4:0] sh;
    sh = lane_shift(alg, nlg, low);
    return ((old & ~(lane_mask(alg) << sh)) | ((val & lane_mask(alg)) << sh)) & lane_mask(nlg);
  endfunction

endpackage

// File: rtl/mwb_width_table.sv
module mwb_width_table
  import mwb_pkg::*;
#(
  parameter int OFFS_W = 10,
  parameter int LIMIT  = 'h200
) (
  input  logic [OFFS_W-3:0] group_idx,
  output nat_width_e        native
);
  localparam int GROUPS         = 1 << (OFFS_W - 2);
  localparam int FIRST_UNMAPPED = (LIMIT >> 2);

  logic [1:0] map_q [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_entry
    assign map_q[g] = default_group_width(g, FIRST_UNMAPPED);
  end

  assign native = nat_width_e'(map_q[group_idx]);
endmodule

// File: rtl/mwb_range_check.sv
module mwb_range_check
  import mwb_pkg::*;
#(
  parameter int OFFS_W = 10,
  parameter int LIMIT  = 'h200
) (
  input  logic [OFFS_W-1:0] off,
  input  logic [1:0]        size,
  input  nat_width_e        native,
  output logic              out_of_range,
  output logic              misaligned,
  output logic              unimpl,
  output logic              err
);
  localparam logic [OFFS_W-1:0] LIMIT_OFF = OFFS_W'(LIMIT);

  assign out_of_range = off > LIMIT_OFF;
  assign unimpl       = native == NW_NONE;

  always_comb begin
    case (acc_size_e'(size))
      AS_BYTE: misaligned = 1'b0;
      AS_HALF: misaligned = off[0];
      AS_WORD: misaligned = |off[1:0];
      default: misaligned = 1'b1;
    endcase
  end

  assign err = out_of_range | unimpl | misaligned;
endmodule

// File: rtl/mwb_sequencer.sv
module mwb_sequencer
  import mwb_pkg::*;
#(
  parameter int OFFS_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [OFFS_W-1:0] req_off,
  input  logic [BUS_W-1:0]  req_wdata,
  input  nat_width_e        req_native,
  input  logic              req_err,
  output logic              busy,
  output logic              rsp_ready,
  output logic              rsp_err,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              reg_valid,
  output logic              reg_write,
  output logic [1:0]        reg_width,
  output logic [OFFS_W-1:0] reg_addr,
  output logic [BUS_W-1:0]  reg_wdata,
  input  logic [BUS_W-1:0]  reg_rdata
);
  seq_state_e        state_q;
  logic [OFFS_W-1:0] off_q;
  logic              wr_q;
  logic [1:0]        alg_q;
  logic [1:0]        nlg_q;
  logic              split_q;
  logic [2:0]        idx_q;
  logic [2:0]        nsub_q;
  logic [BUS_W-1:0]  wdata_q;
  logic [BUS_W-1:0]  old_q;
  logic [BUS_W-1:0]  acc_q;
  logic              err_q;

  // Named events for the checks.
  logic              accept;
  logic              sub_fire;
  logic              last_sub;
  logic              seq_rmw;
  logic [1:0]        req_nlg;
  logic              req_split;
  logic [2:0]        req_nsub;
  logic [OFFS_W-1:0] nbytes;
  logic [OFFS_W-1:0] base_aligned;
  logic [5:0]        split_sh;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign req_nlg   = 2'(req_native) - 2'd1;
  assign req_split = req_size >= req_nlg;
  assign req_nsub  = req_split ? (3'd1 << (req_size - req_nlg))
                               : (req_write ? 3'd2 : 3'd1);

  assign sub_fire     = state_q == ST_RUN;
  assign last_sub     = sub_fire && (idx_q == nsub_q - 3'd1);
  assign seq_rmw      = sub_fire && !split_q && wr_q;
  assign nbytes       = OFFS_W'(1) << nlg_q;
  assign base_aligned = off_q & ~(nbytes - OFFS_W'(1));
  assign split_sh     = 6'(nsub_q - 3'd1 - idx_q) << (3'(nlg_q) + 3'd3);

  always_comb begin
    reg_valid = sub_fire;
    reg_width = sub_fire ? (nlg_q + 2'd1) : 2'd0;
    if (split_q) begin
      reg_addr  = off_q + (OFFS_W'(idx_q) << nlg_q);
      reg_write = sub_fire && wr_q;
      reg_wdata = (wdata_q >> split_sh) & lane_mask(nlg_q);
    end else begin
      reg_addr  = base_aligned;
      reg_write = sub_fire && wr_q && (idx_q == 3'd1);
      reg_wdata = put_lane(old_q, wdata_q, alg_q, nlg_q, off_q[1:0]);
    end
    if (!reg_write) reg_wdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      wr_q    <= 1'b0;
      alg_q   <= 2'd0;
      nlg_q   <= 2'd0;
      split_q <= 1'b0;
      idx_q   <= 3'd0;
      nsub_q  <= 3'd1;
      wdata_q <= '0;
      old_q   <= '0;
      acc_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            off_q   <= req_off;
            wr_q    <= req_write;
            alg_q   <= req_size;
            nlg_q   <= req_nlg;
            split_q <= req_split;
            nsub_q  <= req_nsub;
            wdata_q <= req_wdata & lane_mask(req_size);
            old_q   <= '0;
            acc_q   <= '0;
            idx_q   <= 3'd0;
            err_q   <= req_err;
            state_q <= req_err ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (!wr_q) begin
            if (split_q)
              acc_q <= (acc_q << (6'd8 << nlg_q)) | (reg_rdata & lane_mask(nlg_q));
            else
              acc_q <= pick_lane(reg_rdata, alg_q, nlg_q, off_q[1:0]);
          end else if (!split_q && idx_q == 3'd0) begin
            old_q <= reg_rdata & lane_mask(nlg_q);
          end
          idx_q <= idx_q + 3'd1;
          if (last_sub) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = state_q != ST_IDLE;
  assign rsp_ready = state_q == ST_DONE;
  assign rsp_err   = err_q;
  assign rsp_rdata = acc_q;

  a_r11_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);

  a_r2_err_skips_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && rsp_err) |-> !$past(reg_valid));

  a_r9_rmw_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && !split_q) |->
      ($past(reg_valid && !reg_write) && reg_addr == $past(reg_addr)));

  a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && split_q && idx_q != 3'd0) |-> (reg_addr == $past(reg_addr) + nbytes));

  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_ready) |=> $stable(off_q) && $stable(wdata_q));
endmodule

// File: rtl/mwb_adapter.sv
module mwb_adapter
  import mwb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 10,
  parameter int LIMIT  = 'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              rsp_ready,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              reg_valid,
  output logic              reg_write,
  output logic [1:0]        reg_width,
  output logic [OFFS_W-1:0] reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_rdata
);
  localparam logic [OFFS_W-1:0] LIMIT_OFF = OFFS_W'(LIMIT);

  logic [OFFS_W-1:0] req_off;
  nat_width_e        req_native;
  logic              oor, mis, unimpl, req_err;

  assign req_off = req_addr[OFFS_W-1:0];

  mwb_width_table #(.OFFS_W(OFFS_W), .LIMIT(LIMIT)) u_table (
    .group_idx (req_off[OFFS_W-1:2]),
    .native    (req_native)
  );

  mwb_range_check #(.OFFS_W(OFFS_W), .LIMIT(LIMIT)) u_range (
    .off          (req_off),
    .size         (req_size),
    .native       (req_native),
    .out_of_range (oor),
    .misaligned   (mis),
    .unimpl       (unimpl),
    .err          (req_err)
  );

  mwb_sequencer #(.OFFS_W(OFFS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_off    (req_off),
    .req_wdata  (req_wdata),
    .req_native (req_native),
    .req_err    (req_err),
    .busy       (busy),
    .rsp_ready  (rsp_ready),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_width  (reg_width),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata)
  );

  a_r2_reg_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> reg_addr < LIMIT_OFF);

  a_r3_width_known: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> reg_width != 2'd0);

  a_r4_reg_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> ((reg_width == 2'd2 && !reg_addr[0]) ||
                   (reg_width == 2'd3 && reg_addr[1:0] == 2'd0) ||
                   reg_width == 2'd1));

  a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (oor || mis || unimpl)) |=> (rsp_ready && rsp_err));
endmodule

// File: tb/test_mwb_adapter.sv
`timescale 1ns/100ps
module test_mwb_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic        reg_valid, reg_write;
  logic [1:0]  reg_width;
  logic [9:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #2.5 clk = ~clk;

  mwb_adapter i_mwb_adapter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_width(reg_width),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Behavioural register bank, big-endian bytes.
  logic [7:0] mem [1024];
  logic [7:0] refm [1024];

  always_comb begin
    case (reg_width)
      2'd1:    reg_rdata = {24'd0, mem[int'(reg_addr)]};
      2'd2:    reg_rdata = {16'd0, mem[int'(reg_addr)], mem[int'(reg_addr) + 1]};
      2'd3:    reg_rdata = {mem[int'(reg_addr)], mem[int'(reg_addr) + 1],
                            mem[int'(reg_addr) + 2], mem[int'(reg_addr) + 3]};
      default: reg_rdata = '0;
    endcase
  end

  always @(posedge clk) begin
    if (reg_valid && reg_write) begin
      case (reg_width)
        2'd1: mem[int'(reg_addr)] <= reg_wdata[7:0];
        2'd2: begin
          mem[int'(reg_addr)]     <= reg_wdata[15:8];
          mem[int'(reg_addr) + 1] <= reg_wdata[7:0];
        end
        2'd3: begin
          mem[int'(reg_addr)]     <= reg_wdata[31:24];
          mem[int'(reg_addr) + 1] <= reg_wdata[23:16];
          mem[int'(reg_addr) + 2] <= reg_wdata[15:8];
          mem[int'(reg_addr) + 3] <= reg_wdata[7:0];
        end
        default: ;
      endcase
    end
  end

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nat_bytes(int off);
    if (off >= 'h200) return 0;
    case ((off / 32) % 4)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return (((off / 4) % 2) == 1) ? 0 : 1;
    endcase
  endfunction

  function automatic int code_bytes(logic [1:0] c);
    return (c == 2'd1) ? 1 : (c == 2'd2) ? 2 : (c == 2'd3) ? 4 : 0;
  endfunction

  // Monitor of register accesses.
  int          mon_n = 0;
  logic [9:0]  mon_addr [8];
  bit          mon_wr [8];
  always @(negedge clk) begin
    if (reg_valid && rst_n) begin
      if (mon_n < 8) begin
        mon_addr[mon_n] = reg_addr;
        mon_wr[mon_n]   = reg_write;
      end
      mon_n++;
      chk(code_bytes(reg_width) == nat_bytes(int'(reg_addr)), "R3 native width",
          32'(code_bytes(reg_width)), 32'(nat_bytes(int'(reg_addr))));
    end
  end

  logic [31:0] t_rdata;
  bit          t_err;
  int          t_cycles;

  task automatic txn(input bit wr, input logic [1:0] sz, input logic [15:0] addr, input logic [31:0] wd);
    @(negedge clk);
    mon_n     = 0;
    req_valid = 1'b1;
    req_write = wr;
    req_size  = sz;
    req_addr  = addr;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    t_cycles  = 1;
    while (!rsp_ready && t_cycles < 20) begin
      @(negedge clk);
      t_cycles++;
    end
    t_rdata = rsp_rdata;
    t_err   = rsp_err;
  endtask

  function automatic int exp_count(bit wr, int a, int n);
    if (a > n) return a / n;
    if (a < n) return wr ? 2 : 1;
    return 1;
  endfunction

  function automatic string kind_tag(bit wr, int a, int n);
    if (a == n) return "R5";
    if (!wr) return (a < n) ? "R6" : ((a == 2) ? "R7" : "R8");
    return (a < n) ? "R9" : "R10";
  endfunction

  task automatic check_subs(bit wr, int off, int a, int n, string tag);
    int cnt;
    cnt = exp_count(wr, a, n);
    chk(mon_n == cnt, {tag, " access count"}, 32'(mon_n), 32'(cnt));
    chk(t_cycles == cnt + 1, "R11 latency", 32'(t_cycles), 32'(cnt + 1));
    for (int i = 0; i < cnt && i < mon_n; i++) begin
      int ea;
      bit ew;
      ea = (a >= n) ? off + i * n : off - (off % n);
      ew = (a >= n) ? wr : (wr && i == 1);
      chk(int'(mon_addr[i]) == ea, {tag, " sub address"}, 32'(mon_addr[i]), 32'(ea));
      chk(mon_wr[i] == ew, {tag, " sub direction"}, 32'(mon_wr[i]), 32'(ew));
    end
  endtask

  task automatic check_group(int off, string tag);
    int b;
    b = off - (off % 4);
    for (int j = 0; j < 4; j++)
      chk(mem[b + j] == refm[b + j], {tag, " bank byte"}, 32'(mem[b + j]), 32'(refm[b + j]));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 8'(i * 7 + 3);
      refm[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(!rsp_ready && !busy && !reg_valid, "R11 reset idle",
        {29'd0, rsp_ready, busy, reg_valid}, 32'd0);
    rst_n = 1'b1;

    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < 1024; off++) begin
        int a, n;
        bit e;
        string et, kt;
        logic [31:0] wd, expr;
        logic [15:0] addr;
        a = 1 << sz;
        n = nat_bytes(off);
        e = (sz == 3) || (off % a != 0) || (off > 'h200) || (n == 0);
        et = (sz == 3 || off % a != 0) ? "R4" : (off > 'h200) ? "R2" : "R3";
        addr = 16'(off) | 16'((sz + 1) << 10);
        wd = (32'h9e37_79b9 * 32'(off + 1)) ^ 32'(sz);
        if (sz < 3 && a < 4) wd = wd & ((32'd1 << (8 * a)) - 32'd1);

        txn(1'b1, 2'(sz), addr, wd);
        if (e) begin
          chk(t_err, {et, " write error flag"}, 32'(t_err), 32'd1);
          chk(mon_n == 0, {et, " write no access"}, 32'(mon_n), 32'd0);
          chk(t_cycles == 1, {et, " write latency"}, 32'(t_cycles), 32'd1);
          check_group(off, et);
        end else begin
          kt = kind_tag(1'b1, a, n);
          chk(!t_err, {kt, " write error flag"}, 32'(t_err), 32'd0);
          check_subs(1'b1, off, a, n, kt);
          for (int j = 0; j < a; j++) refm[off + j] = 8'(wd >> (8 * (a - 1 - j)));
          check_group(off, {kt, " R1"});
        end

        txn(1'b0, 2'(sz), addr, 32'hffff_ffff);
        if (e) begin
          chk(t_err, {et, " read error flag"}, 32'(t_err), 32'd1);
          chk(t_rdata == 32'd0, {et, " read zero"}, t_rdata, 32'd0);
          chk(mon_n == 0, {et, " read no access"}, 32'(mon_n), 32'd0);
        end else begin
          kt = kind_tag(1'b0, a, n);
          expr = '0;
          for (int j = 0; j < a; j++) expr = (expr << 8) | 32'(refm[off + j]);
          chk(!t_err, {kt, " read error flag"}, 32'(t_err), 32'd0);
          chk(t_rdata == expr, {kt, " R12 read data"}, t_rdata, expr);
          check_subs(1'b0, off, a, n, kt);
        end
      end
    end

    // R1: alias through high address bits.
    txn(1'b1, 2'd0, 16'hfc10, 32'h0000_00a5);
    refm['h10] = 8'ha5;
    txn(1'b0, 2'd0, 16'h0010, 32'd0);
    chk(t_rdata == 32'h0000_00a5, "R1 alias readback", t_rdata, 32'h0000_00a5);

    // R11: a request held during a busy sequence is not accepted.
    @(negedge clk);
    mon_n     = 0;
    req_valid = 1'b1;
    req_write = 1'b1;
    req_size  = 2'd2;
    req_addr  = 16'h0000;
    req_wdata = 32'h1122_3344;
    @(negedge clk);
    req_addr  = 16'h0004;
    req_wdata = 32'hdead_beef;
    t_cycles  = 1;
    while (!rsp_ready && t_cycles < 20) begin
      @(negedge clk);
      t_cycles++;
    end
    req_valid = 1'b0;
    refm[0] = 8'h11; refm[1] = 8'h22; refm[2] = 8'h33; refm[3] = 8'h44;
    chk(t_cycles == 5, "R11 busy latency", 32'(t_cycles), 32'd5);
    chk(mon_n == 4, "R11 busy access count", 32'(mon_n), 32'd4);
    @(negedge clk);
    @(negedge clk);
    chk(!busy, "R11 no second accept", 32'(busy), 32'd0);
    check_group(0, "R11 first write");
    check_group(4, "R11 ignored write");

    summary();
  end
endmodule